// File: doc/BRIEF.md
# Serial port register and interrupt front end

This block is the software-facing side of a serial port. A word-indexed register bus reaches control registers, two status registers, a test/status register and a set of baud and timing registers. The block also sits on a byte-wide character interface. Bytes written to the transmit-data index leave as a single-cycle strobe. Incoming characters, and break events, land in a one-entry holding buffer. A single level interrupt is built from the status and control bits.

Receive flow control is a one-character handshake. The block offers `rx_ready` only while the holding buffer is free. Reading the receive-data index hands the character to software, marks it valid in bit 15 and frees the buffer again. Software starts a soft reset by writing control register 2 with bit 0 at zero. Bit-level serialisation, FIFOs and real baud generation are not part of the block.

Top module: `uart_regif`

## Requirements
- R1: Reset values, read from the ports: status 1 = 0x6040, status 2 = 0x4028, test (index 0x2D) = 0x0060, control 1 (0x20) = 0, control 2 (0x21) = 0x0001, control 3 (0x22) = 0x0700, modulator (0x2A) = 0, baud count (0x2B) = 4, FIFO control (0x24) = 0, millisecond (0x2C) = 0, holding buffer = 0x4000.
- R2: A read of index 0x00 returns the holding buffer. When test bit 5 (receive empty) is clear, bit 15 is ORed into the returned value. That read also clears status 1 bit 9 and status 2 bit 0, and sets test bit 5.
- R3: `irq` is high when control 1 bit 9 and status 1 bit 9 are both set, or when control 1 bit 13, control 1 bit 6 and status 1 bit 13 are all set. `irq` follows the registered flags.
- R4: A write to index 0x21 with bit 0 = 0 returns every register to its R1 value. Control 2 then stores the low 16 bits of the written data with bit 0 forced to 1.
- R5: Writes to control 1, 2 and 3, FIFO control, modulator, millisecond and baud increment keep only the low 16 bits of the bus data.
- R6: A write to status 1 (0x25) clears only the bits that are set in both the data and mask 0x9DB0. A write to status 2 (0x26) clears only the bits that are set in both the data and mask 0xBDD6. Status 1 bit 9 and status 2 bit 0 are never changed by these writes.
- R7: A write to index 0x10 produces `tx_valid` for exactly one cycle, on the cycle after the write, with `tx_data` equal to the low byte. This happens only when control 2 bit 2 is set. Otherwise the write is dropped.
- R8: `rx_ready` is the inverse of status 1 bit 9. A character on `rx_valid` is accepted only while `rx_ready` is high. Accepting it stores the byte, sets status 1 bit 9 and status 2 bit 0, and clears test bit 5. Characters offered while the buffer is full are lost.
- R9: An `rx_break` pulse is accepted under the same rule as R8 and stores the code 0x0800. It takes priority over a character offered in the same cycle.
- R10: Index 0x29 (baud increment) and 0x23 (control 4) read as 0. A write to 0x29 lands in the baud count register read at 0x2B. Writes to 0x2B, 0x23 and 0x2D have no effect.
- R11: Read data appears on `reg_rdata` one cycle after `reg_rd` and holds until the next read. Unmapped indices read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_addr | input | ADDR_W (10) | Word index (byte offset shifted right by 2) |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | BUS_W (32) | Write data |
| reg_rdata | output | BUS_W (32) | Registered read data |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Incoming character strobe |
| rx_data | input | 8 | Incoming character |
| rx_break | input | 1 | Break event strobe |
| rx_ready | output | 1 | Holding buffer free |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are those where the holding buffer is full and something else happens. These include a second character or a break arriving, a status write trying to clear the receive flag, and a soft reset throwing the pending character away. Directed steps fill the buffer first and then apply each of these. A random phase then mixes reads, writes, characters and breaks against a behavioural model. This reaches reads of an empty buffer, soft resets with the receive interrupt enabled, and transmit writes with the transmitter switched off.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    localparam int REG_W  = 16;
    localparam int CHAR_W = 8;

    typedef logic [REG_W-1:0] reg16_t;

    // word indices
    localparam int IDX_RXD   = 'h00;
    localparam int IDX_TXD   = 'h10;
    localparam int IDX_CTRL1 = 'h20;
    localparam int IDX_CTRL2 = 'h21;
    localparam int IDX_CTRL3 = 'h22;
    localparam int IDX_CTRL4 = 'h23;
    localparam int IDX_FCTL  = 'h24;
    localparam int IDX_STAT1 = 'h25;
    localparam int IDX_STAT2 = 'h26;
    localparam int IDX_BINC  = 'h29;
    localparam int IDX_BMOD  = 'h2A;
    localparam int IDX_BCNT  = 'h2B;
    localparam int IDX_MSEC  = 'h2C;
    localparam int IDX_TEST  = 'h2D;

    // bit positions
    localparam int S1_TXRDY   = 13;
    localparam int S1_RXRDY   = 9;
    localparam int S2_DRDY    = 0;
    localparam int C1_TXRDYIE = 13;
    localparam int C1_RXIE    = 9;
    localparam int C1_TXEIE   = 6;
    localparam int C2_TXEN    = 2;
    localparam int C2_SRST    = 0;
    localparam int T_RXE      = 5;
    localparam int RXD_VALID  = 15;

    localparam reg16_t S1_W1C   = 16'h9DB0;
    localparam reg16_t S2_W1C   = 16'hBDD6;
    localparam reg16_t BRK_CODE = 16'h0800;

    typedef struct packed {
        reg16_t              ctrl1;
        reg16_t              ctrl2;
        reg16_t              ctrl3;
        reg16_t              fctl;
        reg16_t              stat1;
        reg16_t              stat2;
        reg16_t              bmod;
        reg16_t              bcnt;
        reg16_t              msec;
        reg16_t              test;
        reg16_t              rxbuf;
        logic                tx_v;
        logic [CHAR_W-1:0]   tx_b;
        reg16_t              rdata;
    } state_t;

    localparam state_t STATE_RST = '{
        ctrl1: 16'h0000, ctrl2: 16'h0001, ctrl3: 16'h0700, fctl: 16'h0000,
        stat1: 16'h6040, stat2: 16'h4028, bmod: 16'h0000, bcnt: 16'h0004,
        msec: 16'h0000, test: 16'h0060, rxbuf: 16'h4000,
        tx_v: 1'b0, tx_b: '0, rdata: 16'h0000
    };

endpackage

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
    import uart_regif_pkg::*;
(
    input  reg16_t ctrl,
    input  reg16_t stat,
    output logic   irq
);
    logic rx_term;
    logic tx_term;
    logic unused_bits;

    assign rx_term     = ctrl[C1_RXIE] & stat[S1_RXRDY];
    assign tx_term     = ctrl[C1_TXRDYIE] & ctrl[C1_TXEIE] & stat[S1_TXRDY];
    assign irq         = rx_term | tx_term;
    assign unused_bits = ^{ctrl, stat};
endmodule

// File: rtl/uart_regif_rdmux.sv
module uart_regif_rdmux
    import uart_regif_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  state_t            st,
    output reg16_t            value
);
    logic unused_st;
    assign unused_st = ^{st.tx_v, st.tx_b, st.rdata};

    always_comb begin
        value = '0;
        case (int'(addr))
            IDX_RXD: begin
                value = st.rxbuf;
                if (!st.test[T_RXE]) value[RXD_VALID] = 1'b1;
            end
            IDX_CTRL1: value = st.ctrl1;
            IDX_CTRL2: value = st.ctrl2;
            IDX_CTRL3: value = st.ctrl3;
            IDX_FCTL:  value = st.fctl;
            IDX_STAT1: value = st.stat1;
            IDX_STAT2: value = st.stat2;
            IDX_BMOD:  value = st.bmod;
            IDX_BCNT:  value = st.bcnt;
            IDX_MSEC:  value = st.msec;
            IDX_TEST:  value = st.test;
            default:   value = '0;
        endcase
    end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BUS_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [BUS_W-1:0]   reg_wdata,
    output logic [BUS_W-1:0]   reg_rdata,
    output logic               tx_valid,
    output logic [CHAR_W-1:0]  tx_data,
    input  logic               rx_valid,
    input  logic [CHAR_W-1:0]  rx_data,
    input  logic               rx_break,
    output logic               rx_ready,
    output logic               irq
);
    localparam int PAD_W = BUS_W - REG_W;

    state_t st_q, st_d;
    reg16_t rd_val;
    reg16_t wlo;
    logic   rx_take;
    logic   unused_whi;

    assign wlo        = reg_wdata[REG_W-1:0];
    assign unused_whi = ^reg_wdata[BUS_W-1:REG_W];
    assign rx_take    = !st_q.stat1[S1_RXRDY] && (rx_valid || rx_break);

    uart_regif_rdmux #(.ADDR_W(ADDR_W)) rdmux_i (
        .addr  (reg_addr),
        .st    (st_q),
        .value (rd_val)
    );

    uart_regif_irq irq_i (
        .ctrl (st_q.ctrl1),
        .stat (st_q.stat1),
        .irq  (irq)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tx_v = 1'b0;

        // hand the held character to software
        if (reg_rd && int'(reg_addr) == IDX_RXD && !st_q.test[T_RXE]) begin
            st_d.stat1[S1_RXRDY] = 1'b0;
            st_d.stat2[S2_DRDY]  = 1'b0;
            st_d.test[T_RXE]     = 1'b1;
        end

        if (reg_wr) begin
            case (int'(reg_addr))
                IDX_TXD: begin
                    if (st_q.ctrl2[C2_TXEN]) begin
                        st_d.tx_v = 1'b1;
                        st_d.tx_b = reg_wdata[CHAR_W-1:0];
                    end
                end
                IDX_CTRL1: st_d.ctrl1 = wlo;
                IDX_CTRL2: begin
                    if (!wlo[C2_SRST]) begin
                        st_d       = STATE_RST;
                        st_d.rdata = st_q.rdata;
                        st_d.tx_b  = st_q.tx_b;
                        st_d.ctrl2 = wlo | reg16_t'(1 << C2_SRST);
                    end else begin
                        st_d.ctrl2 = wlo;
                    end
                end
                IDX_CTRL3: st_d.ctrl3 = wlo;
                IDX_FCTL:  st_d.fctl  = wlo;
                IDX_BINC:  st_d.bcnt  = wlo;
                IDX_BMOD:  st_d.bmod  = wlo;
                IDX_MSEC:  st_d.msec  = wlo;
                IDX_STAT1: st_d.stat1 = st_d.stat1 & ~(wlo & S1_W1C);
                IDX_STAT2: st_d.stat2 = st_d.stat2 & ~(wlo & S2_W1C);
                default: ;
            endcase
        end

        if (rx_take) begin
            st_d.rxbuf           = rx_break ? BRK_CODE : reg16_t'(rx_data);
            st_d.stat1[S1_RXRDY] = 1'b1;
            st_d.stat2[S2_DRDY]  = 1'b1;
            st_d.test[T_RXE]     = 1'b0;
        end

        if (reg_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= STATE_RST;
        else        st_q <= st_d;
    end

    assign reg_rdata = {{PAD_W{1'b0}}, st_q.rdata};
    assign tx_valid  = st_q.tx_v;
    assign tx_data   = st_q.tx_b;
    assign rx_ready  = ~st_q.stat1[S1_RXRDY];
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
    import uart_regif_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BUS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [BUS_W-1:0]  reg_rdata,
    input logic              tx_valid,
    input logic              rx_valid,
    input logic              rx_break,
    input logic              rx_ready,
    input logic              irq,
    input logic              rx_ie,
    input logic              txr_ie,
    input logic              txe_ie
);
    // R7: a transmit strobe always follows a write to the transmit index
    a_r7_tx_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(reg_wr && int'(reg_addr) == IDX_TXD));

    // R8: accepting a character closes the handshake
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && (rx_valid || rx_break) && !reg_wr) |=> !rx_ready);

    // R2: reading receive data frees the buffer
    a_r2_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && int'(reg_addr) == IDX_RXD && !reg_wr && !rx_valid && !rx_break) |=> rx_ready);

    // R3: a held character with its enable set raises the interrupt
    a_r3_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && rx_ie) |-> irq);

    // R3: no interrupt without an enable path
    a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_ie || (txr_ie && txe_ie)));

    // R11: unmapped index reads zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && int'(reg_addr) == 'h30) |=> reg_rdata == '0);
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .tx_valid  (tx_valid),
    .rx_valid  (rx_valid),
    .rx_break  (rx_break),
    .rx_ready  (rx_ready),
    .irq       (irq),
    .rx_ie     (st_q.ctrl1[9]),
    .txr_ie    (st_q.ctrl1[13]),
    .txe_ie    (st_q.ctrl1[6])
);

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_break = 1'b0;
    logic        rx_ready;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int tx_cnt = 0;
    logic [7:0] tx_last = '0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    uart_regif dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_break(rx_break), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_c1, m_c2, m_c3, m_fc, m_s1, m_s2, m_bm, m_bc, m_ms, m_ts, m_buf;
    logic [15:0] m_rdata = '0;
    logic        m_txv = 1'b0;
    logic [7:0]  m_txd = '0;
    logic        m_rchk = 1'b0;

    task automatic m_reset();
        m_c1 = 0; m_c2 = 16'h1; m_c3 = 16'h700; m_fc = 0; m_s1 = 16'h6040;
        m_s2 = 16'h4028; m_bm = 0; m_bc = 4; m_ms = 0; m_ts = 16'h60; m_buf = 16'h4000;
    endtask

    function automatic logic [15:0] m_read(input int a);
        case (a)
            'h00: return m_buf | (m_ts[5] ? 16'h0 : 16'h8000);
            'h20: return m_c1;  'h21: return m_c2;  'h22: return m_c3;
            'h24: return m_fc;  'h25: return m_s1;  'h26: return m_s2;
            'h2A: return m_bm;  'h2B: return m_bc;  'h2C: return m_ms;
            'h2D: return m_ts;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        return (m_c1[9] & m_s1[9]) | (m_c1[13] & m_c1[6] & m_s1[13]);
    endfunction

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset(); m_txv = 0; m_rchk = 0;
        end else begin
            logic full;
            logic [15:0] rv, w;
            full   = m_s1[9];
            rv     = m_read(int'(reg_addr));
            w      = reg_wdata[15:0];
            m_txv  = 0;
            m_rchk = reg_rd;
            if (reg_rd && reg_addr == 0 && !m_ts[5]) begin
                m_s1[9] = 0; m_s2[0] = 0; m_ts[5] = 1;
            end
            if (reg_wr) begin
                case (int'(reg_addr))
                    'h10: if (m_c2[2]) begin m_txv = 1; m_txd = reg_wdata[7:0]; end
                    'h20: m_c1 = w;
                    'h21: if (!w[0]) begin m_reset(); m_c2 = w | 16'h1; end else m_c2 = w;
                    'h22: m_c3 = w;
                    'h24: m_fc = w;
                    'h29: m_bc = w;
                    'h2A: m_bm = w;
                    'h2C: m_ms = w;
                    'h25: m_s1 = m_s1 & ~(w & 16'h9DB0);
                    'h26: m_s2 = m_s2 & ~(w & 16'hBDD6);
                    default: ;
                endcase
            end
            if (!full && (rx_valid || rx_break)) begin
                m_buf = rx_break ? 16'h0800 : {8'h0, rx_data};
                m_s1[9] = 1; m_s2[0] = 1; m_ts[5] = 0;
            end
            if (reg_rd) m_rdata = rv;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 irq", {31'b0, irq}, {31'b0, m_irq()});
            chk("R8 rx_ready", {31'b0, rx_ready}, {31'b0, ~m_s1[9]});
            chk("R7 tx_valid", {31'b0, tx_valid}, {31'b0, m_txv});
            if (m_txv) chk("R7 tx_data", {24'b0, tx_data}, {24'b0, m_txd});
            if (m_rchk) chk("R11 rdata", reg_rdata, {16'b0, m_rdata});
        end
        if (rst_n && tx_valid) begin tx_cnt++; tx_last = tx_data; end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_wr(input int a, input logic [31:0] v);
        @(negedge clk); reg_wr = 1; reg_addr = 10'(a); reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] v);
        @(negedge clk); reg_rd = 1; reg_addr = 10'(a);
        @(negedge clk); reg_rd = 0; v = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic rx_push(input logic [7:0] d, input logic brk);
        @(negedge clk); rx_valid = !brk; rx_break = brk; rx_data = d;
        @(negedge clk); rx_valid = 0; rx_break = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n0;
        int addrs [15] = '{'h00, 'h10, 'h20, 'h21, 'h22, 'h23, 'h24, 'h25,
                           'h26, 'h29, 'h2A, 'h2B, 'h2C, 'h2D, 'h30};
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        rd_chk("R1 status1", 'h25, 32'h6040);
        rd_chk("R1 status2", 'h26, 32'h4028);
        rd_chk("R1 test", 'h2D, 32'h0060);
        rd_chk("R1 ctrl1", 'h20, 32'h0);
        rd_chk("R1 ctrl2", 'h21, 32'h1);
        rd_chk("R1 ctrl3", 'h22, 32'h700);
        rd_chk("R1 bcount", 'h2B, 32'h4);
        rd_chk("R1 bmod", 'h2A, 32'h0);
        rd_chk("R1 rxbuf no valid bit", 'h00, 32'h4000);

        // R7 transmit gating
        n0 = tx_cnt;
        bus_wr('h10, 32'h1A5); @(negedge clk);
        chk("R7 dropped while disabled", tx_cnt - n0, 0);
        bus_wr('h21, 32'h5);
        bus_wr('h10, 32'h1A5); @(negedge clk);
        chk("R7 one pulse", tx_cnt - n0, 1);
        chk("R7 low byte", {24'b0, tx_last}, 32'hA5);

        // R8 / R2 receive handshake
        rx_push(8'h5C, 0);
        chk("R8 ready low when full", {31'b0, rx_ready}, 0);
        rx_push(8'h33, 0);
        rd_chk("R8 status1 rx flag", 'h25, 32'h6240);
        rd_chk("R8 status2 data flag", 'h26, 32'h4029);
        rd_chk("R8 test rx empty clear", 'h2D, 32'h0040);
        rd_chk("R2 read with valid bit", 'h00, 32'h805C);
        rd_chk("R2 reread without valid bit", 'h00, 32'h005C);
        rd_chk("R2 status1 flag cleared", 'h25, 32'h6040);

        // R3 interrupt
        bus_wr('h20, 32'h200);
        chk("R3 idle no irq", {31'b0, irq}, 0);
        rx_push(8'h11, 0);
        chk("R3 rx irq", {31'b0, irq}, 1);
        rd_chk("R2 rx char", 'h00, 32'h8011);
        chk("R3 irq drops after read", {31'b0, irq}, 0);
        bus_wr('h20, 32'h2000);
        chk("R3 tx ready needs empty enable", {31'b0, irq}, 0);
        bus_wr('h20, 32'h2040);
        chk("R3 tx ready irq", {31'b0, irq}, 1);
        bus_wr('h20, 32'h0);

        // R9 break
        rx_push(8'h77, 1);
        rd_chk("R9 break code", 'h00, 32'h8800);

        // R6 status writes
        rx_push(8'h42, 0);
        bus_wr('h25, 32'hFFFF_FFFF);
        rd_chk("R6 status1 unchanged", 'h25, 32'h6240);
        bus_wr('h26, 32'h0000_FFFF);
        rd_chk("R6 status2 unchanged", 'h26, 32'h4029);
        rd_chk("R6 char kept", 'h00, 32'h8042);

        // R5 / R10 storage registers
        bus_wr('h22, 32'h1234_5678); rd_chk("R5 ctrl3 low half", 'h22, 32'h5678);
        bus_wr('h24, 32'hDEAD_BEEF); rd_chk("R5 fifo ctl", 'h24, 32'hBEEF);
        bus_wr('h2C, 32'hFFFF_0003); rd_chk("R5 msec", 'h2C, 32'h3);
        bus_wr('h2A, 32'h0001_8888); rd_chk("R5 bmod", 'h2A, 32'h8888);
        bus_wr('h29, 32'hABCD_1234);
        rd_chk("R10 increment reads zero", 'h29, 32'h0);
        rd_chk("R10 increment lands in count", 'h2B, 32'h1234);
        bus_wr('h2B, 32'h99); rd_chk("R10 count write ignored", 'h2B, 32'h1234);
        bus_wr('h2D, 32'hFF); rd_chk("R10 test write ignored", 'h2D, 32'h60);
        bus_wr('h23, 32'hFF); rd_chk("R10 ctrl4 reads zero", 'h23, 32'h0);
        bus_wr('h20, 32'hF0F0_0201); rd_chk("R5 ctrl1 low half", 'h20, 32'h0201);

        // R11 unmapped
        bus_wr('h30, 32'h5); rd_chk("R11 unmapped zero", 'h30, 32'h0);
        rd_chk("R11 top index zero", 'h3FF, 32'h0);

        // R4 soft reset with a held character
        rx_push(8'h99, 0);
        chk("R4 irq before reset", {31'b0, irq}, 1);
        bus_wr('h21, 32'h0001_0004);
        chk("R4 irq after reset", {31'b0, irq}, 0);
        chk("R4 buffer freed", {31'b0, rx_ready}, 1);
        rd_chk("R4 ctrl2 bit0 forced", 'h21, 32'h5);
        rd_chk("R4 ctrl1 cleared", 'h20, 32'h0);
        rd_chk("R4 ctrl3 default", 'h22, 32'h700);
        rd_chk("R4 count default", 'h2B, 32'h4);
        rd_chk("R4 fifo ctl cleared", 'h24, 32'h0);
        rd_chk("R4 buffer default", 'h00, 32'h4000);
        n0 = tx_cnt;
        bus_wr('h10, 32'h3C); @(negedge clk);
        chk("R7 tx after soft reset", tx_cnt - n0, 1);

        // random mix against the model
        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            int a;
            op = $urandom_range(0, 3);
            a  = addrs[$urandom_range(0, 14)];
            case (op)
                0: begin logic [31:0] v; bus_rd(a, v); end
                1: bus_wr(a, (a == 'h21 && $urandom_range(0, 3) != 0) ? ($urandom | 32'h1) : $urandom);
                2: rx_push(8'($urandom), $urandom_range(0, 5) == 0);
                default: @(negedge clk);
            endcase
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule